// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block decides which of two bus masters owns a shared external memory bus. It talks to the other master over three handshake lines: a hold line, a hold-acknowledge line and a bus-request line. A single mode input sets the role of this side. As the granting master, it hands the bus to an external requester and then signals that it wants the bus back. As the requesting slave, it asks an external master for the bus and uses it only while that master acknowledges. Only the direction of the acknowledge line changes between the two roles, so two devices can be wired directly together with no glue logic.

On the local side, the local bus sequencer reports whether a bus cycle is in progress (`seq_busy`) and whether an access is waiting (`seq_pending`). The arbiter tells the sequencer to tri-state its address, data and strobe drivers through `bus_float`. Each handshake pin appears as an input, an output value and an output enable, so the pad buffers stay outside the block. Every handshake signal in this block is active high. When arbitration is disabled, the block leaves all three pins undriven and the local bus belongs to the local sequencer.

Top module: `xbus_share_arb`

## Requirements
- R1: While `arb_en` is low, `hold_oe`, `hlda_oe` and `breq_oe` are 0, `hold_o`, `hlda_o` and `breq_o` are 0, and `bus_float` is 0, whatever the levels on `hold_i` and `hlda_i`.
- R2: With `arb_en` high and `slave_mode` low (granting role), `hlda_oe` and `breq_oe` are 1 and `hold_oe` is 0. With `slave_mode` high (requesting role), `hold_oe` is 1 and `hlda_oe` and `breq_oe` are 0.
- R3: `hold_i` and `hlda_i` pass through a two-stage synchroniser. A level applied just after a rising edge is not visible at any output at the second rising edge that follows.
- R4: In the granting role with the local bus idle, a `hold_i` that has been raised drives `hlda_o` and `bus_float` to 1 at the third rising edge.
- R5: In the granting role, the grant waits while `seq_busy` is 1. It takes effect at the first rising edge at which the synchronised hold is active and `seq_busy` is 0.
- R6: In the granting role, `breq_o` equals `seq_pending` while the bus is granted away, and it is 0 at all other times.
- R7: In the granting role, after `hold_i` is removed, `hlda_o` falls at the third rising edge while `bus_float` stays 1. `bus_float` returns to 0 only at the fourth edge, which leaves one idle cycle.
- R8: In the requesting role, when not owning the bus, `bus_float` is 1. A `seq_pending` of 1 raises `hold_o` at the next rising edge.
- R9: In the requesting role with `hold_o` high, a `hlda_i` that has been raised drives `bus_float` to 0 at the third rising edge.
- R10: In the requesting role while owning the bus, when `seq_pending` and `seq_busy` are both 0, `hold_o` falls and `bus_float` rises at the next rising edge.
- R11: In the requesting role, if `hlda_i` is removed while owning the bus, `bus_float` rises and `hold_o` falls at the third rising edge. One idle cycle follows. If `seq_pending` is still 1, `hold_o` rises again at the fifth edge.
- R12: After reset in the granting role the local side owns the bus (`bus_float` 0, `hlda_o` 0). In the requesting role it starts without the bus (`bus_float` 1, `hold_o` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Arbitration enable |
| slave_mode | input | 1 | 0 selects the granting role, 1 the requesting role |
| seq_busy | input | 1 | Local bus cycle in progress |
| seq_pending | input | 1 | Local access waiting for the bus |
| hold_i | input | 1 | Hold pin level (granting role) |
| hold_o | output | 1 | Hold pin drive value (requesting role) |
| hold_oe | output | 1 | Hold pin output enable |
| hlda_i | input | 1 | Acknowledge pin level (requesting role) |
| hlda_o | output | 1 | Acknowledge pin drive value (granting role) |
| hlda_oe | output | 1 | Acknowledge pin output enable |
| breq_o | output | 1 | Bus-request pin drive value |
| breq_oe | output | 1 | Bus-request pin output enable |
| bus_float | output | 1 | Tells the sequencer to tri-state the local bus |

## Verification
The checker assumes that `arb_en` and `slave_mode` change only while arbitration is disabled. It also assumes that the sequencer does not raise `seq_busy` while `bus_float` is high, or in the cycle in which a grant is decided. The bench changes the mode only by dropping `arb_en` for two cycles first. It raises `seq_busy` only while the local side owns the bus and no hold is pending. It also holds each handshake level for at least three edges before it expects a reaction.

// File: rtl/xarb_pkg.sv
// Shared types for the external bus arbiter.
package xarb_pkg;

    // Granting-role states.
    typedef enum logic [1:0] {
        MS_OWN     = 2'd0,
        MS_GRANT   = 2'd1,
        MS_RECLAIM = 2'd2
    } mst_state_e;

    // Requesting-role states.
    typedef enum logic [2:0] {
        SL_IDLE = 3'd0,
        SL_REQ  = 3'd1,
        SL_OWN  = 3'd2,
        SL_REL  = 3'd3,
        SL_GAP  = 3'd4
    } slv_state_e;

endpackage

// File: rtl/xarb_sync.sv
// Multi-stage level synchroniser for asynchronous handshake inputs.
// Assumes inputs are levels held well beyond STAGES clock cycles.
module xarb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    // Remaining stages form the shift chain.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xarb_master.sv
// Granting-role FSM: yields the bus to an external requester once the
// local bus cycle has ended, and returns through one idle cycle.
// Assumes hold_s is already synchronised; resets to MS_OWN when inactive.
module xarb_master
    import xarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hold_s,
    input  logic seq_busy,
    input  logic seq_pending,
    output logic grant_o,
    output logic float_o,
    output logic breq_o
);
    mst_state_e state_q, state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = MS_OWN;
        end else begin
            case (state_q)
                MS_OWN:     if (hold_s && !seq_busy) state_d = MS_GRANT;
                MS_GRANT:   if (!hold_s)             state_d = MS_RECLAIM;
                MS_RECLAIM:                          state_d = MS_OWN;
                default:                             state_d = MS_OWN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_OWN;
        else        state_q <= state_d;
    end

    assign grant_o = (state_q == MS_GRANT);
    assign float_o = (state_q != MS_OWN);
    assign breq_o  = grant_o && seq_pending;
endmodule

// File: rtl/xarb_slave.sv
// Requesting-role FSM: raises hold when a local access waits, owns the bus
// only while the synchronised acknowledge is active, and drops back through
// an idle cycle when the acknowledge is withdrawn.
// Assumes hlda_s is already synchronised; resets to SL_IDLE when inactive.
module xarb_slave
    import xarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hlda_s,
    input  logic seq_busy,
    input  logic seq_pending,
    output logic hold_o,
    output logic float_o
);
    slv_state_e state_q, state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = SL_IDLE;
        end else begin
            case (state_q)
                SL_IDLE: if (seq_pending && !hlda_s) state_d = SL_REQ;
                SL_REQ:  if (hlda_s)                 state_d = SL_OWN;
                SL_OWN: begin
                    if (!hlda_s)                          state_d = SL_GAP;
                    else if (!seq_pending && !seq_busy)   state_d = SL_REL;
                end
                SL_REL:  if (!hlda_s)                state_d = SL_IDLE;
                SL_GAP:                              state_d = SL_IDLE;
                default:                             state_d = SL_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    assign hold_o  = (state_q == SL_REQ) || (state_q == SL_OWN);
    assign float_o = (state_q != SL_OWN);
endmodule

// File: rtl/xbus_share_arb.sv
// Top of the shared external bus arbiter. Selects the granting or requesting
// role, synchronises the handshake pins and steers pin values and enables.
// Assumes arb_en and slave_mode change only while arbitration is disabled.
module xbus_share_arb #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_en,
    input  logic slave_mode,
    input  logic seq_busy,
    input  logic seq_pending,
    input  logic hold_i,
    output logic hold_o,
    output logic hold_oe,
    input  logic hlda_i,
    output logic hlda_o,
    output logic hlda_oe,
    output logic breq_o,
    output logic breq_oe,
    output logic bus_float
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins_raw, pins_s;
    logic m_active, s_active;
    logic m_grant, m_float, m_breq;
    logic s_hold, s_float;

    assign pins_raw = {hlda_i, hold_i};
    assign m_active = arb_en && !slave_mode;
    assign s_active = arb_en && slave_mode;

    xarb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    xarb_master u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (m_active),
        .hold_s      (pins_s[0]),
        .seq_busy    (seq_busy),
        .seq_pending (seq_pending),
        .grant_o     (m_grant),
        .float_o     (m_float),
        .breq_o      (m_breq)
    );

    xarb_slave u_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (s_active),
        .hlda_s      (pins_s[1]),
        .seq_busy    (seq_busy),
        .seq_pending (seq_pending),
        .hold_o      (s_hold),
        .float_o     (s_float)
    );

    // Pin steering: only the active role drives its lines.
    always_comb begin
        hold_oe   = s_active;
        hold_o    = s_active && s_hold;
        hlda_oe   = m_active;
        hlda_o    = m_active && m_grant;
        breq_oe   = m_active;
        breq_o    = m_active && m_breq;
        bus_float = m_active ? m_float : (s_active ? s_float : 1'b0);
    end
endmodule

// File: rtl/xarb_chk.sv
// Property checker for the shared bus arbiter, bound to the top module.
module xarb_chk (
    input logic clk,
    input logic rst_n,
    input logic arb_en,
    input logic slave_mode,
    input logic seq_busy,
    input logic seq_pending,
    input logic hold_i,
    input logic hold_o,
    input logic hold_oe,
    input logic hlda_i,
    input logic hlda_o,
    input logic hlda_oe,
    input logic breq_o,
    input logic breq_oe,
    input logic bus_float
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |-> (!hold_oe && !hlda_oe && !breq_oe && !bus_float));

    // R2
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_oe && hlda_oe));

    // R5
    grant_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && !slave_mode && $rose(hlda_o)) |-> !$past(seq_busy));

    // R4
    grant_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && !slave_mode && hlda_o) |-> bus_float);

    // R6
    breq_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        breq_o |-> (hlda_o && bus_float));

    // R7
    reclaim_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && $past(arb_en) && !slave_mode && $fell(hlda_o)) |-> bus_float);

    // R9
    slave_owns_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && slave_mode && !bus_float) |-> hold_o);

    // R8
    slave_requested_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && $past(arb_en) && slave_mode && $fell(bus_float)) |-> $past(hold_o));
endmodule

bind xbus_share_arb xarb_chk u_chk (.*);

// File: tb/xbus_share_arb_tb.sv
// Directed bench for the shared external bus arbiter.
module xbus_share_arb_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_en = 1'b0, slave_mode = 1'b0;
    logic seq_busy = 1'b0, seq_pending = 1'b0;
    logic hold_i = 1'b0, hlda_i = 1'b0;
    logic hold_o, hold_oe, hlda_o, hlda_oe, breq_o, breq_oe, bus_float;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xbus_share_arb u_dut (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .slave_mode(slave_mode),
        .seq_busy(seq_busy), .seq_pending(seq_pending),
        .hold_i(hold_i), .hold_o(hold_o), .hold_oe(hold_oe),
        .hlda_i(hlda_i), .hlda_o(hlda_o), .hlda_oe(hlda_oe),
        .breq_o(breq_o), .breq_oe(breq_oe), .bus_float(bus_float)
    );

    // Advance n rising edges, then move 1 ns past the edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic en, input logic slv);
        arb_en = 1'b0;
        tick(2);
        slave_mode = slv;
        arb_en = en;
    endtask

    task automatic t_reset;
        arb_en = 1'b1; slave_mode = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R12", "master bus_float", bus_float, 1'b0);
        chk("R12", "master hlda_o", hlda_o, 1'b0);
        chk("R2", "master hlda_oe", hlda_oe, 1'b1);
        chk("R2", "master breq_oe", breq_oe, 1'b1);
        chk("R2", "master hold_oe", hold_oe, 1'b0);
    endtask

    task automatic t_disabled;
        set_mode(1'b0, 1'b0);
        hold_i = 1'b1; hlda_i = 1'b1;
        tick(5);
        chk("R1", "hlda_o", hlda_o, 1'b0);
        chk("R1", "bus_float", bus_float, 1'b0);
        chk("R1", "hlda_oe", hlda_oe, 1'b0);
        chk("R1", "hold_oe", hold_oe, 1'b0);
        chk("R1", "breq_oe", breq_oe, 1'b0);
        hold_i = 1'b0; hlda_i = 1'b0;
        tick(3);
    endtask

    task automatic t_master_grant;
        set_mode(1'b1, 1'b0);
        tick(2);
        hold_i = 1'b1;
        tick(2);
        chk("R3", "hlda_o after 2 edges", hlda_o, 1'b0);
        tick(1);
        chk("R4", "hlda_o", hlda_o, 1'b1);
        chk("R4", "bus_float", bus_float, 1'b1);
        seq_pending = 1'b0;
        tick(0);
        chk("R6", "breq_o no pending", breq_o, 1'b0);
        seq_pending = 1'b1;
        #1;
        chk("R6", "breq_o pending", breq_o, 1'b1);
        hold_i = 1'b0;
        tick(2);
        chk("R7", "hlda_o still high", hlda_o, 1'b1);
        tick(1);
        chk("R7", "hlda_o dropped", hlda_o, 1'b0);
        chk("R7", "idle cycle float", bus_float, 1'b1);
        chk("R6", "breq_o after grant", breq_o, 1'b0);
        tick(1);
        chk("R7", "bus reclaimed", bus_float, 1'b0);
        seq_pending = 1'b0;
    endtask

    task automatic t_master_busy;
        seq_busy = 1'b1;
        tick(1);
        hold_i = 1'b1;
        tick(6);
        chk("R5", "no grant while busy", hlda_o, 1'b0);
        chk("R5", "not floated while busy", bus_float, 1'b0);
        seq_busy = 1'b0;
        tick(1);
        chk("R5", "grant after busy", hlda_o, 1'b1);
        hold_i = 1'b0;
        tick(5);
    endtask

    task automatic t_slave_cycle;
        set_mode(1'b1, 1'b1);
        tick(1);
        chk("R12", "slave float", bus_float, 1'b1);
        chk("R12", "slave hold_o", hold_o, 1'b0);
        chk("R2", "slave hold_oe", hold_oe, 1'b1);
        chk("R2", "slave hlda_oe", hlda_oe, 1'b0);
        chk("R2", "slave breq_oe", breq_oe, 1'b0);
        seq_pending = 1'b1;
        tick(1);
        chk("R8", "hold_o raised", hold_o, 1'b1);
        chk("R8", "still floating", bus_float, 1'b1);
        hlda_i = 1'b1;
        tick(2);
        chk("R9", "float before sync", bus_float, 1'b1);
        tick(1);
        chk("R9", "owns bus", bus_float, 1'b0);
        seq_busy = 1'b1;
        seq_pending = 1'b0;
        tick(3);
        chk("R10", "kept while busy", bus_float, 1'b0);
        seq_busy = 1'b0;
        tick(1);
        chk("R10", "hold_o dropped", hold_o, 1'b0);
        chk("R10", "bus floated", bus_float, 1'b1);
        hlda_i = 1'b0;
        tick(4);
    endtask

    task automatic t_slave_forced;
        seq_pending = 1'b1;
        tick(1);
        hlda_i = 1'b1;
        tick(3);
        chk("R9", "owns again", bus_float, 1'b0);
        hlda_i = 1'b0;
        tick(2);
        chk("R11", "owns until sync", bus_float, 1'b0);
        tick(1);
        chk("R11", "float on takeback", bus_float, 1'b1);
        chk("R11", "hold_o low on takeback", hold_o, 1'b0);
        tick(1);
        chk("R11", "idle cycle hold_o", hold_o, 1'b0);
        tick(1);
        chk("R11", "re-request", hold_o, 1'b1);
        seq_pending = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_master_grant();
        t_master_busy();
        t_slave_cycle();
        t_slave_forced();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule